// File: doc/BRIEF.md
# VPW Bus Receive Glitch Filter

This block sits between the raw receive pin of a variable pulse-width serial bus and the symbol synchronization logic. It brings the asynchronous pin into the clock domain through a two-flop synchronizer. It then times every active and passive level in microsecond units and passes on only the level changes that outlast the noise window. Each level is sorted into one of three classes by its length: noise, an invalid symbol, or a valid symbol.

A 2-bit prescale code divides the module clock, which runs at one of four working frequencies (4, 6, 8 or 10 MHz), down to a one-microsecond tick. A bus level that lasts 8 us or less never shows at the filtered output. A level that lasts 9 us or more is accepted. The filtered output then changes, and a one-cycle strobe presents the measured length of the level that just ended. That length is counted from accepted edge to accepted edge, so a short spike inside a level does not split it. An accepted level shorter than 34 us sets a sticky timing-error flag, which is cleared by a one-cycle clear pulse.

Top module: `vpw_glitch_filter`

## Requirements
- R1: After reset, rxLevel is 0 (passive), edgeStrobe is 0, edgeDuration is 0 and timingErr is 0.
- R2: The microsecond tick is the module clock divided by 4, 6, 8 or 10 for preSel codes 00, 01, 10 and 11. A 50 us pulse at any code therefore measures 49 to 51.
- R3: A change of rxRaw whose new level lasts 8 us or less (at most 8 ticks) leaves rxLevel unchanged and produces no edgeStrobe.
- R4: A new rxRaw level that lasts 9 us or more is copied to rxLevel. The copy happens later than 8 us and no later than 9 us plus 4 clock cycles after the raw change.
- R5: edgeStrobe is high for exactly one clock cycle, in the same cycle that rxLevel takes its new value, and at no other time.
- R6: With edgeStrobe, edgeDuration gives the length in microsecond ticks of the level that just ended, within 1 of the raw length. A suppressed spike inside that level does not shorten it, and edgeDuration holds its value between strobes.
- R7: An accepted level whose edgeDuration is below 34 sets timingErr in the strobe cycle. A duration of 34 or more does not set it.
- R8: timingErr stays set until errClear is high for a cycle. A new short level in the same cycle wins over the clear.
- R9: The duration count saturates at 2^DUR_W-1 (255 by default) and does not wrap during long idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock at the working frequency |
| rstN | input | 1 | Active-low asynchronous reset |
| rxRaw | input | 1 | Asynchronous raw bus receive level, 1 = active |
| preSel | input | 2 | Prescale code: 00/01/10/11 divide by 4/6/8/10 |
| errClear | input | 1 | Write-one-to-clear for timingErr |
| rxLevel | output | 1 | Filtered bus level |
| edgeStrobe | output | 1 | One-cycle pulse on each accepted level change |
| edgeDuration | output | DUR_W | Length in us of the level that just ended |
| timingErr | output | 1 | Sticky flag for an accepted level shorter than 34 us |

## Verification
A stuck or miscounting spike counter shows up within 9 us of a raw edge: rxLevel either follows a short spike or fails to follow a long level. A wrong prescale divisor or level counter appears at the very next strobe as an edgeDuration off by a fixed ratio. A bad error register appears in the cycle after an invalid or valid symbol ends, or as a flag that drops without a clear. The directed pulses are placed well clear of the 8, 9 and 34 us edges, except for one exact 8 us spike, so that the single-tick phase uncertainty cannot hide a fault.

// File: rtl/vpw_filt_pkg.sv
package vpw_filt_pkg;
  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic countSpike;   // advance the spike counter
    logic clearSpike;   // synced input agrees with filtered level
    logic accept;       // take the new level, emit the duration
    logic flagErr;      // accepted level was too short
  } filtCtrl_t;
endpackage

// File: rtl/vpw_filt_datapath.sv
module vpw_filt_datapath
  import vpw_filt_pkg::*;
#(
  parameter int DUR_W = 8,
  parameter int NOISE_US = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxRaw,
  input  logic [1:0]         preSel,
  input  logic               errClear,
  input  filtCtrl_t          ctrl,
  output logic               tick,
  output logic               syncRx,
  output logic [$clog2(NOISE_US+1)-1:0] spikeCnt,
  output logic [DUR_W-1:0]   durNext,
  output logic               rxLevel,
  output logic               edgeStrobe,
  output logic [DUR_W-1:0]   edgeDuration,
  output logic               timingErr
);
  localparam int PRE_W = 4;
  localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncChain;
  logic [PRE_W-1:0]       preCnt;
  logic [PRE_W-1:0]       preLast;
  logic [DUR_W-1:0]       levelCnt;

  // two (or more) flop synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxRaw};
  end
  assign syncRx = syncChain[SYNC_STAGES-1];

  // microsecond prescaler: divide by 4 + 2*preSel
  assign preLast = PRE_W'({preSel, 1'b0}) + PRE_W'(3);
  assign tick    = (preCnt >= preLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // time the synced input has disagreed with the filtered level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             spikeCnt <= '0;
    else if (ctrl.clearSpike || ctrl.accept) spikeCnt <= '0;
    else if (ctrl.countSpike)              spikeCnt <= spikeCnt + 1'b1;
  end

  // level length, saturating
  assign durNext = (levelCnt == DUR_MAX) ? DUR_MAX : levelCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            levelCnt <= '0;
    else if (ctrl.accept) levelCnt <= '0;
    else if (tick)        levelCnt <= durNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLevel      <= 1'b0;
      edgeStrobe   <= 1'b0;
      edgeDuration <= '0;
      timingErr    <= 1'b0;
    end else begin
      edgeStrobe <= ctrl.accept;
      if (ctrl.accept) begin
        rxLevel      <= syncRx;
        edgeDuration <= durNext;
      end
      if (ctrl.flagErr)  timingErr <= 1'b1;
      else if (errClear) timingErr <= 1'b0;
    end
  end
endmodule

// File: rtl/vpw_filt_ctrl.sv
module vpw_filt_ctrl
  import vpw_filt_pkg::*;
#(
  parameter int DUR_W = 8,
  parameter int NOISE_US = 8,
  parameter int VALID_US = 34
) (
  input  logic               tick,
  input  logic               syncRx,
  input  logic               rxLevel,
  input  logic [$clog2(NOISE_US+1)-1:0] spikeCnt,
  input  logic [DUR_W-1:0]   durNext,
  output filtCtrl_t          ctrl
);
  localparam int SPK_W = $clog2(NOISE_US+1);

  logic mismatch;
  logic atLimit;

  assign mismatch = (syncRx != rxLevel);
  assign atLimit  = (spikeCnt == SPK_W'(NOISE_US));

  always_comb begin
    ctrl.clearSpike = !mismatch;
    ctrl.countSpike = mismatch && tick && !atLimit;
    ctrl.accept     = mismatch && tick && atLimit;
    ctrl.flagErr    = ctrl.accept && (durNext < DUR_W'(VALID_US));
  end
endmodule

// File: rtl/vpw_glitch_filter.sv
module vpw_glitch_filter #(
  parameter int DUR_W = 8,
  parameter int NOISE_US = 8,
  parameter int VALID_US = 34
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxRaw,
  input  logic [1:0]       preSel,
  input  logic             errClear,
  output logic             rxLevel,
  output logic             edgeStrobe,
  output logic [DUR_W-1:0] edgeDuration,
  output logic             timingErr
);
  import vpw_filt_pkg::*;
  localparam int SPK_W = $clog2(NOISE_US+1);

  filtCtrl_t        ctrl;
  logic             tick;
  logic             syncRx;
  logic [SPK_W-1:0] spikeCnt;
  logic [DUR_W-1:0] durNext;

  vpw_filt_datapath #(.DUR_W(DUR_W), .NOISE_US(NOISE_US), .SYNC_STAGES(2)) i_dp (
    .clk(clk), .rstN(rstN), .rxRaw(rxRaw), .preSel(preSel), .errClear(errClear),
    .ctrl(ctrl), .tick(tick), .syncRx(syncRx), .spikeCnt(spikeCnt),
    .durNext(durNext), .rxLevel(rxLevel), .edgeStrobe(edgeStrobe),
    .edgeDuration(edgeDuration), .timingErr(timingErr)
  );

  vpw_filt_ctrl #(.DUR_W(DUR_W), .NOISE_US(NOISE_US), .VALID_US(VALID_US)) i_ctrl (
    .tick(tick), .syncRx(syncRx), .rxLevel(rxLevel), .spikeCnt(spikeCnt),
    .durNext(durNext), .ctrl(ctrl)
  );
endmodule

// File: rtl/vpw_glitch_filter_chk.sv
module vpw_glitch_filter_chk #(
  parameter int DUR_W = 8,
  parameter int VALID_US = 34
) (
  input logic             clk,
  input logic             rstN,
  input logic             errClear,
  input logic             rxLevel,
  input logic             edgeStrobe,
  input logic [DUR_W-1:0] edgeDuration,
  input logic             timingErr
);
  // R5: a level change always comes with the strobe
  assert_change_has_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != $past(rxLevel)) |-> edgeStrobe);

  // R5: a strobe always comes with a level change
  assert_strobe_has_change_R5: assert property (@(posedge clk) disable iff (!rstN)
    edgeStrobe |-> (rxLevel != $past(rxLevel)));

  // R5: the strobe is one cycle wide
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    edgeStrobe |=> !edgeStrobe);

  // R6: the duration holds between strobes
  assert_duration_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !edgeStrobe |-> $stable(edgeDuration));

  // R7: a short accepted level raises the flag
  assert_short_sets_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (edgeStrobe && edgeDuration < DUR_W'(VALID_US)) |-> timingErr);

  // R7: the flag only rises for a short accepted level
  assert_err_rise_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timingErr) |-> (edgeStrobe && edgeDuration < DUR_W'(VALID_US)));

  // R8: sticky until cleared
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timingErr && !errClear) |=> timingErr);
endmodule

bind vpw_glitch_filter vpw_glitch_filter_chk #(.DUR_W(DUR_W), .VALID_US(VALID_US)) i_chk (
  .clk(clk), .rstN(rstN), .errClear(errClear), .rxLevel(rxLevel),
  .edgeStrobe(edgeStrobe), .edgeDuration(edgeDuration), .timingErr(timingErr)
);

// File: tb/test_vpw_glitch_filter.sv
module test_vpw_glitch_filter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxRaw = 1'b0;
  logic       errClear = 1'b0;
  logic [1:0] preSel = 2'b00;
  logic       rxLevel;
  logic       edgeStrobe;
  logic [7:0] edgeDuration;
  logic       timingErr;

  int checks = 0;
  int fails = 0;
  int strobeCount = 0;
  int lastDur = 0;
  int lastLevel = 0;
  int div = 4;

  always #4 clk = ~clk;

  vpw_glitch_filter i_vpw_glitch_filter (
    .clk(clk), .rstN(rstN), .rxRaw(rxRaw), .preSel(preSel), .errClear(errClear),
    .rxLevel(rxLevel), .edgeStrobe(edgeStrobe), .edgeDuration(edgeDuration),
    .timingErr(timingErr)
  );

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && edgeStrobe) begin
      strobeCount <= strobeCount + 1;
      lastDur     <= int'(edgeDuration);
      lastLevel   <= int'(rxLevel);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic usWait(input int n);
    waitCyc(n * div);
  endtask

  task automatic checkDur(input string req, input int exp);
    check(lastDur >= exp - 1 && lastDur <= exp + 1, req, "edgeDuration", lastDur, exp);
  endtask

  task automatic testReset;
    check(rxLevel == 1'b0, "R1", "rxLevel", int'(rxLevel), 0);
    check(edgeStrobe == 1'b0, "R1", "edgeStrobe", int'(edgeStrobe), 0);
    check(edgeDuration == 8'd0, "R1", "edgeDuration", int'(edgeDuration), 0);
    check(timingErr == 1'b0, "R1", "timingErr", int'(timingErr), 0);
  endtask

  task automatic testNoise;
    int s0 = strobeCount;
    rxRaw = 1'b1; usWait(4); rxRaw = 1'b0; usWait(20);
    check(rxLevel == 1'b0, "R3", "level after 4us spike", int'(rxLevel), 0);
    check(strobeCount == s0, "R3", "strobes after 4us spike", strobeCount, s0);
    rxRaw = 1'b1; usWait(8); rxRaw = 1'b0; usWait(20);
    check(rxLevel == 1'b0, "R3", "level after 8us spike", int'(rxLevel), 0);
    check(strobeCount == s0, "R3", "strobes after 8us spike", strobeCount, s0);
    check(timingErr == 1'b0, "R3", "timingErr after spikes", int'(timingErr), 0);
    usWait(20);
  endtask

  task automatic testValid;
    int s0 = strobeCount;
    rxRaw = 1'b1;
    waitCyc(8 * div);
    check(rxLevel == 1'b0, "R4", "level at 8us", int'(rxLevel), 0);
    waitCyc(div + 4);
    check(rxLevel == 1'b1, "R4", "level at 9us", int'(rxLevel), 1);
    check(strobeCount == s0 + 1, "R5", "strobes on rise", strobeCount, s0 + 1);
    check(lastLevel == 1, "R5", "level with strobe", lastLevel, 1);
    waitCyc(41 * div - 4);
    rxRaw = 1'b0; usWait(12);
    check(rxLevel == 1'b0, "R4", "level after fall", int'(rxLevel), 0);
    check(strobeCount == s0 + 2, "R5", "strobes after pulse", strobeCount, s0 + 2);
    checkDur("R6", 50);
    check(timingErr == 1'b0, "R7", "timingErr after 50us", int'(timingErr), 0);
    usWait(30);
  endtask

  task automatic testInvalid;
    rxRaw = 1'b1; usWait(20); rxRaw = 1'b0; usWait(12);
    check(timingErr == 1'b1, "R7", "timingErr after 20us", int'(timingErr), 1);
    checkDur("R7", 20);
    usWait(20);
    check(timingErr == 1'b1, "R8", "timingErr held", int'(timingErr), 1);
    errClear = 1'b1; waitCyc(1); errClear = 1'b0; waitCyc(1);
    check(timingErr == 1'b0, "R8", "timingErr cleared", int'(timingErr), 0);
    usWait(30);
  endtask

  task automatic testDip;
    int s0 = strobeCount;
    rxRaw = 1'b1; usWait(20);
    rxRaw = 1'b0; usWait(3);
    rxRaw = 1'b1; usWait(37);
    rxRaw = 1'b0; usWait(12);
    check(strobeCount == s0 + 2, "R6", "strobes with dip", strobeCount, s0 + 2);
    checkDur("R6", 60);
    check(timingErr == 1'b0, "R6", "timingErr with dip", int'(timingErr), 0);
    usWait(30);
  endtask

  task automatic testSaturation;
    usWait(300);
    rxRaw = 1'b1; usWait(12);
    check(lastDur == 255, "R9", "saturated duration", lastDur, 255);
    check(lastLevel == 1, "R9", "level after idle", lastLevel, 1);
    usWait(38);
    rxRaw = 1'b0; usWait(40);
  endtask

  task automatic testPrescale(input logic [1:0] code);
    preSel = code;
    div = 4 + 2 * int'(code);
    usWait(40);
    rxRaw = 1'b1; usWait(50); rxRaw = 1'b0; usWait(12);
    checkDur("R2", 50);
    check(timingErr == 1'b0, "R2", "timingErr at new prescale", int'(timingErr), 0);
    usWait(30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(5);
    testReset();
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    usWait(50);
    testNoise();
    testValid();
    testInvalid();
    testDip();
    testSaturation();
    testPrescale(2'b11);
    testPrescale(2'b01);
    testPrescale(2'b10);
    testPrescale(2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule